// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller for a 32-bit multicycle processor datapath. The datapath shares a single memory between instructions and data. It has one ALU, an instruction register, a memory data register, two operand latches and an ALU result latch. The controller holds a 4-bit state. It reads the 6-bit opcode from the instruction register and the ALU zero flag. In every cycle it produces the full set of datapath controls: memory read and write strobes, the address source select, the instruction-register and PC write enables, the PC source, the ALU function, both ALU operand selects, the immediate extension mode, and the register-file write enable with its destination and data selects.

Each instruction starts in a fetch state. Fetch reads memory at the PC into the instruction register and stores PC+4 into the PC in the same cycle. The decode state that follows latches the operands and forms the branch target ahead of time. The controller then dispatches on the opcode to a short execute, memory and write-back sequence. R-type, OR-immediate, load word, store word and branch-if-equal are handled. Any other opcode goes straight back to fetch and writes nothing. The controller also gives the datapath a single PC load strobe. This strobe merges the unconditional PC write with the zero-gated branch write.

Top module: `mcc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset places the controller in fetch, even in the middle of an instruction. Fetch drives mem_rd=1, ir_wr=1, pc_wr=1, iord=0, alu_sel_a=0, alu_sel_b=00 and alu_op=00.
- R2: The cycle after fetch is decode. Decode drives alu_sel_a=0, alu_sel_b=10, ext_op=1 and alu_op=00, with every write enable and memory strobe at 0.
- R3: After decode the controller branches on the opcode. Opcode 000000 goes to R-type execute, 001101 to OR-immediate execute, 100011 to load address, 101011 to store address and 000100 to branch compare.
- R4: R-type runs execute (alu_sel_a=1, alu_sel_b=01, alu_op=10), then write-back (reg_wr=1, reg_dst=1, mem_to_reg=0), then fetch.
- R5: OR-immediate runs execute (alu_sel_a=1, alu_sel_b=11, ext_op=0, alu_op=11), then write-back (reg_wr=1, reg_dst=0, mem_to_reg=0), then fetch.
- R6: Load word runs an address step (alu_sel_a=1, alu_sel_b=11, ext_op=1, alu_op=00), then a read step (mem_rd=1, iord=1), then write-back (reg_wr=1, reg_dst=0, mem_to_reg=1), then fetch.
- R7: Store word runs the same address step as load, then a write step (mem_wr=1, iord=1), then fetch.
- R8: Branch-equal takes a single compare step (alu_sel_a=1, alu_sel_b=01, alu_op=01, pc_wr_cond=1, pc_src=1) and then returns to fetch.
- R9: pc_en equals pc_wr OR (pc_wr_cond AND alu_zero) in every cycle. It is therefore 1 in fetch whatever the zero flag, and in the compare step it follows the flag.
- R10: An unrecognised opcode in decode returns the controller to fetch on the next cycle, and no write enable or memory strobe is asserted in between.
- R11: mem_rd and mem_wr are never both 1. Every control output not named for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address source: 0 PC, 1 ALU result latch |
| ir_wr | output | 1 | Instruction register write enable |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write gated by the zero flag |
| pc_src | output | 1 | PC source: 0 ALU output, 1 ALU result latch |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field, 11 OR |
| alu_sel_a | output | 1 | First ALU operand: 0 PC, 1 operand A |
| alu_sel_b | output | 2 | Second operand: 00 constant 4, 01 operand B, 10 immediate shifted by 2, 11 immediate |
| ext_op | output | 1 | 1 sign extension, 0 zero extension |
| reg_wr | output | 1 | Register file write enable |
| reg_dst | output | 1 | Destination: 1 rd field, 0 rt field |
| mem_to_reg | output | 1 | Write data: 1 memory data register, 0 ALU result latch |
| pc_en | output | 1 | Merged PC load strobe |

## Verification
Two PC updates compete in this block. In fetch, the instruction-register load and the PC increment happen in the same cycle. In the branch compare step, a subtraction and a PC write that depends on it share one cycle. The bench drives the zero flag opposite to its branch value during fetch to show that the increment ignores it. It then runs branch-equal with the flag both set and clear. The merged PC load strobe and the unconditional write enable are compared against the expected values in each of these cycles.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;
    localparam int ALUOP_W = 2;
    localparam int SELB_W  = 2;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_BRCMP   = 4'd2,
        ST_RX_EXE  = 4'd4,
        ST_RX_WB   = 4'd5,
        ST_OR_EXE  = 4'd6,
        ST_OR_WB   = 4'd7,
        ST_LD_ADDR = 4'd8,
        ST_LD_READ = 4'd9,
        ST_LD_WB   = 4'd10,
        ST_ST_ADDR = 4'd11,
        ST_ST_WRT  = 4'd12
    } state_e;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_OR   = 2'b11
    } alu_op_e;

    typedef enum logic [SELB_W-1:0] {
        SB_FOUR    = 2'b00,
        SB_REG_B   = 2'b01,
        SB_IMM_SL2 = 2'b10,
        SB_IMM     = 2'b11
    } selb_e;

    typedef struct packed {
        logic    mem_rd;
        logic    mem_wr;
        logic    iord;
        logic    ir_wr;
        logic    pc_wr;
        logic    pc_wr_cond;
        logic    pc_src;
        alu_op_e alu_op;
        logic    sel_a;
        selb_e   sel_b;
        logic    ext_op;
        logic    reg_wr;
        logic    reg_dst;
        logic    mem_to_reg;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c.mem_rd     = 1'b0;
        c.mem_wr     = 1'b0;
        c.iord       = 1'b0;
        c.ir_wr      = 1'b0;
        c.pc_wr      = 1'b0;
        c.pc_wr_cond = 1'b0;
        c.pc_src     = 1'b0;
        c.alu_op     = ALU_ADD;
        c.sel_a      = 1'b0;
        c.sel_b      = SB_FOUR;
        c.ext_op     = 1'b0;
        c.reg_wr     = 1'b0;
        c.reg_dst    = 1'b0;
        c.mem_to_reg = 1'b0;
        return c;
    endfunction

    function automatic state_e dispatch(input logic [OPC_W-1:0] op);
        case (op)
            OPC_RTYPE: return ST_RX_EXE;
            OPC_ORI:   return ST_OR_EXE;
            OPC_LW:    return ST_LD_ADDR;
            OPC_SW:    return ST_ST_ADDR;
            OPC_BEQ:   return ST_BRCMP;
            default:   return ST_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/mcc_seq_next.sv
module mcc_seq_next
    import mcc_pkg::*;
(
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);
    always_comb begin
        case (cur)
            ST_FETCH:   nxt = ST_DECODE;
            ST_DECODE:  nxt = dispatch(opcode);
            ST_RX_EXE:  nxt = ST_RX_WB;
            ST_OR_EXE:  nxt = ST_OR_WB;
            ST_LD_ADDR: nxt = ST_LD_READ;
            ST_LD_READ: nxt = ST_LD_WB;
            ST_ST_ADDR: nxt = ST_ST_WRT;
            default:    nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
    import mcc_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = ctrl_idle();
        case (cur)
            ST_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_wr  = 1'b1;
                ctl.pc_wr  = 1'b1;
                ctl.sel_b  = SB_FOUR;
                ctl.alu_op = ALU_ADD;
            end
            ST_DECODE: begin
                ctl.sel_b  = SB_IMM_SL2;
                ctl.ext_op = 1'b1;
                ctl.alu_op = ALU_ADD;
            end
            ST_BRCMP: begin
                ctl.sel_a      = 1'b1;
                ctl.sel_b      = SB_REG_B;
                ctl.alu_op     = ALU_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = 1'b1;
            end
            ST_RX_EXE: begin
                ctl.sel_a  = 1'b1;
                ctl.sel_b  = SB_REG_B;
                ctl.alu_op = ALU_FUNC;
            end
            ST_RX_WB: begin
                ctl.reg_wr  = 1'b1;
                ctl.reg_dst = 1'b1;
            end
            ST_OR_EXE: begin
                ctl.sel_a  = 1'b1;
                ctl.sel_b  = SB_IMM;
                ctl.alu_op = ALU_OR;
            end
            ST_OR_WB: begin
                ctl.reg_wr = 1'b1;
            end
            ST_LD_ADDR, ST_ST_ADDR: begin
                ctl.sel_a  = 1'b1;
                ctl.sel_b  = SB_IMM;
                ctl.ext_op = 1'b1;
                ctl.alu_op = ALU_ADD;
            end
            ST_LD_READ: begin
                ctl.mem_rd = 1'b1;
                ctl.iord   = 1'b1;
            end
            ST_LD_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            ST_ST_WRT: begin
                ctl.mem_wr = 1'b1;
                ctl.iord   = 1'b1;
            end
            default: ctl = ctrl_idle();
        endcase
    end
endmodule

// File: rtl/mcc_pc_gate.sv
module mcc_pc_gate (
    input  logic pc_wr,
    input  logic pc_wr_cond,
    input  logic zero,
    output logic pc_en
);
    always_comb pc_en = pc_wr | (pc_wr_cond & zero);
endmodule

// File: rtl/mcc_ctrl_fsm.sv
module mcc_ctrl_fsm
    import mcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               alu_zero,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               iord,
    output logic               ir_wr,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               pc_src,
    output logic [ALUOP_W-1:0] alu_op,
    output logic               alu_sel_a,
    output logic [SELB_W-1:0]  alu_sel_b,
    output logic               ext_op,
    output logic               reg_wr,
    output logic               reg_dst,
    output logic               mem_to_reg,
    output logic               pc_en
);
    state_e state_q;
    state_e state_d;
    ctrl_t  ctl;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    mcc_seq_next u_next (
        .cur    (state_q),
        .opcode (opcode),
        .nxt    (state_d)
    );

    mcc_ctrl_decode u_dec (
        .cur (state_q),
        .ctl (ctl)
    );

    mcc_pc_gate u_pcg (
        .pc_wr      (ctl.pc_wr),
        .pc_wr_cond (ctl.pc_wr_cond),
        .zero       (alu_zero),
        .pc_en      (pc_en)
    );

    always_comb begin
        mem_rd     = ctl.mem_rd;
        mem_wr     = ctl.mem_wr;
        iord       = ctl.iord;
        ir_wr      = ctl.ir_wr;
        pc_wr      = ctl.pc_wr;
        pc_wr_cond = ctl.pc_wr_cond;
        pc_src     = ctl.pc_src;
        alu_op     = ctl.alu_op;
        alu_sel_a  = ctl.sel_a;
        alu_sel_b  = ctl.sel_b;
        ext_op     = ctl.ext_op;
        reg_wr     = ctl.reg_wr;
        reg_dst    = ctl.reg_dst;
        mem_to_reg = ctl.mem_to_reg;
    end
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk
    import mcc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [OPC_W-1:0]   opcode,
    input logic               alu_zero,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               iord,
    input logic               ir_wr,
    input logic               pc_wr,
    input logic               pc_wr_cond,
    input logic               pc_src,
    input logic [ALUOP_W-1:0] alu_op,
    input logic               alu_sel_a,
    input logic [SELB_W-1:0]  alu_sel_b,
    input logic               ext_op,
    input logic               reg_wr,
    input logic               reg_dst,
    input logic               mem_to_reg,
    input logic               pc_en
);
    logic in_decode;
    logic op_known;
    assign in_decode = (alu_sel_b == 2'b10) && !pc_wr;
    assign op_known  = (opcode == OPC_RTYPE) || (opcode == OPC_ORI) || (opcode == OPC_LW) ||
                       (opcode == OPC_SW) || (opcode == OPC_BEQ);

    p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_rd && ir_wr && pc_wr && !iord));

    p_decode_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (in_decode && ext_op && !mem_rd && !mem_wr && !reg_wr && !pc_wr_cond));

    p_load_dispatch_r3: assert property (@(posedge clk) disable iff (rst)
        (in_decode && opcode == OPC_LW) |=> (alu_sel_a && alu_sel_b == 2'b11 && ext_op && alu_op == 2'b00));

    p_wb_then_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    p_load_read_wb_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && iord) |=> (reg_wr && mem_to_reg && !reg_dst));

    p_store_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    p_branch_step_r8: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (alu_op == 2'b01 && pc_src && alu_sel_a && !pc_wr));

    p_pc_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        pc_en == (pc_wr || (pc_wr_cond && alu_zero)));

    p_unknown_to_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (in_decode && !op_known) |=> ir_wr);

    p_mem_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mcc_ctrl_fsm mcc_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .alu_zero   (alu_zero),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .iord       (iord),
    .ir_wr      (ir_wr),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_src     (pc_src),
    .alu_op     (alu_op),
    .alu_sel_a  (alu_sel_a),
    .alu_sel_b  (alu_sel_b),
    .ext_op     (ext_op),
    .reg_wr     (reg_wr),
    .reg_dst    (reg_dst),
    .mem_to_reg (mem_to_reg),
    .pc_en      (pc_en)
);

// File: tb/sim_mcc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mcc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic mem_rd, mem_wr, iord, ir_wr, pc_wr, pc_wr_cond, pc_src;
    logic [1:0] alu_op;
    logic alu_sel_a;
    logic [1:0] alu_sel_b;
    logic ext_op, reg_wr, reg_dst, mem_to_reg, pc_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    typedef enum int {B_FETCH, B_DEC, B_BRC, B_RX, B_RW, B_OX, B_OW,
                      B_LA, B_LR, B_LW, B_SA, B_SW} step_e;

    always #2 clk = ~clk;

    mcc_ctrl_fsm u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .iord(iord), .ir_wr(ir_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
        .alu_op(alu_op), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
        .ext_op(ext_op), .reg_wr(reg_wr), .reg_dst(reg_dst),
        .mem_to_reg(mem_to_reg), .pc_en(pc_en)
    );

    // Expected controls, built from the requirement text.
    function automatic logic [16:0] expect_vec(input step_e s, input logic z);
        logic rd, wr, ad, ir, pw, pc, ps, sa, ex, rw, rdst, m2r, en;
        logic [1:0] op, sb;
        {rd, wr, ad, ir, pw, pc, ps, sa, ex, rw, rdst, m2r} = '0;
        op = 2'b00; sb = 2'b00;
        case (s)
            B_FETCH: begin rd = 1; ir = 1; pw = 1; end
            B_DEC:   begin sb = 2'b10; ex = 1; end
            B_BRC:   begin sa = 1; sb = 2'b01; op = 2'b01; pc = 1; ps = 1; end
            B_RX:    begin sa = 1; sb = 2'b01; op = 2'b10; end
            B_RW:    begin rw = 1; rdst = 1; end
            B_OX:    begin sa = 1; sb = 2'b11; op = 2'b11; end
            B_OW:    begin rw = 1; end
            B_LA, B_SA: begin sa = 1; sb = 2'b11; ex = 1; end
            B_LR:    begin rd = 1; ad = 1; end
            B_LW:    begin rw = 1; m2r = 1; end
            B_SW:    begin wr = 1; ad = 1; end
            default: ;
        endcase
        en = pw | (pc & z);
        return {rd, wr, ad, ir, pw, pc, ps, op, sa, sb, ex, rw, rdst, m2r, en};
    endfunction

    task automatic step(input step_e s, input logic z, input string tag);
        alu_zero = z;
        exp_q.push_back(expect_vec(s, z));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic run_instr(input logic [5:0] op, input logic z);
        opcode = op;
        step(B_FETCH, ~z, "R9");           // fetch ignores zero flag
        case (op)
            6'b000000: begin step(B_DEC, z, "R2"); step(B_RX, z, "R3/R4"); step(B_RW, z, "R4"); end
            6'b001101: begin step(B_DEC, z, "R2"); step(B_OX, z, "R3/R5"); step(B_OW, z, "R5"); end
            6'b100011: begin step(B_DEC, z, "R2"); step(B_LA, z, "R3/R6"); step(B_LR, z, "R6");
                             step(B_LW, z, "R6"); end
            6'b101011: begin step(B_DEC, z, "R2"); step(B_SA, z, "R3/R7"); step(B_SW, z, "R7"); end
            6'b000100: begin step(B_DEC, z, "R2"); step(B_BRC, z, "R8"); end
            default:   begin step(B_DEC, z, "R10"); end
        endcase
    endtask

    // Monitor: pops one expected item per cycle, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [16:0] got;
                logic [16:0] want;
                string t;
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                got  = {mem_rd, mem_wr, iord, ir_wr, pc_wr, pc_wr_cond, pc_src, alu_op,
                        alu_sel_a, alu_sel_b, ext_op, reg_wr, reg_dst, mem_to_reg, pc_en};
                checks++;
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s controls got %b expected %b (R11 field layout)", t, got, want);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        @(negedge clk);
        step(B_FETCH, 1'b0, "R1");         // reset state
        step(B_FETCH, 1'b1, "R1");
        rst = 1'b0;

        run_instr(6'b000000, 1'b0);
        run_instr(6'b001101, 1'b1);
        run_instr(6'b100011, 1'b0);
        run_instr(6'b101011, 1'b1);
        run_instr(6'b000100, 1'b1);        // R8 taken branch, pc_en=1
        run_instr(6'b000100, 1'b0);        // R8 not taken, pc_en=0
        run_instr(6'b000010, 1'b1);        // R10 unknown opcode
        run_instr(6'b111111, 1'b0);        // R10 unknown opcode

        // R1: reset in the middle of a load
        opcode = 6'b100011;
        step(B_FETCH, 1'b0, "R9");
        step(B_DEC, 1'b0, "R2");
        rst = 1'b1;
        step(B_LA, 1'b0, "R6");
        rst = 1'b0;
        step(B_FETCH, 1'b1, "R1");
        step(B_DEC, 1'b0, "R2");
        step(B_LA, 1'b0, "R6");
        step(B_LR, 1'b0, "R6");
        step(B_LW, 1'b1, "R6");

        run_instr(6'b101011, 1'b0);
        run_instr(6'b000100, 1'b1);
        run_instr(6'b001101, 1'b0);

        @(negedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 scoreboard left %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule